// File: doc/BRIEF.md
# Comparator Edge Interrupt Flag

This block converts the digital output of an analog voltage comparator into a latched interrupt flag. The comparator output is high when its positive input is above its negative input and low otherwise. It arrives with no relation to the system clock. It is first brought into the clock domain by a synchronizer chain, and then watched for a low-to-high transition. Each such transition sets a sticky flag. Software clears the flag by writing a zero into the flag's bit position through a simple register write port.

Because the flag is set by an edge and not by a level, clearing it while the comparator is still high leaves it clear. A new set needs the comparator to drop low and rise again. An enable input gates the interrupt request pin, and it has no effect on the flag. The block has no streaming data path, so every pin is a plain level-style control or status signal.

Top module: `cmp_edge_irq`

## Requirements
- R1: During and right after reset, `flag_o` and `irq_o` are 0 and the synchronizer holds 0.
- R2: A low-to-high change of `cmp_async` that is held steady sets `flag_o` after the third rising clock edge that follows it (two synchronizer stages and one edge-history register).
- R3: While `cmp_async` stays high, a flag cleared by software stays clear.
- R4: A write with `wr_en`=1 and bit `FLAG_BIT` (default 0) of `wr_data` equal to 0 clears `flag_o` at that clock edge. The other bits of `wr_data` are ignored.
- R5: After a clear, the flag sets again only once `cmp_async` has gone low and then risen again.
- R6: A write with bit `FLAG_BIT` equal to 1 leaves `flag_o` unchanged, and so does any cycle with `wr_en`=0.
- R7: When a detected rising edge and a clearing write fall on the same clock edge, the flag ends up set.
- R8: `irq_o` is high exactly when `flag_o` is high and `irq_en` is high. Changing `irq_en` never changes `flag_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmp_async | input | 1 | Comparator output, asynchronous to clk |
| wr_en | input | 1 | Write strobe for the interrupt-flag register |
| wr_data | input | DATA_W | Write data, bit FLAG_BIT addresses this flag |
| irq_en | input | 1 | Interrupt request enable |
| flag_o | output | 1 | Latched comparator interrupt flag |
| irq_o | output | 1 | Interrupt request, flag gated by enable |

## Verification
On every cycle, the checker confirms the following: a detected rising edge always leaves the flag set, whether or not a clear arrives in the same cycle. A clearing write without an edge always leaves the flag clear. The flag never rises without a detected edge. It holds steady when neither event occurs, and the request never appears without both the flag and the enable. Only the bench's scenarios can show the end-to-end sequences. These are the three-edge latency from the pin, the refusal to set again while the comparator stays high after a clear, the fall-then-rise needed to set it again, and the exact cycle alignment of the set-over-clear collision.

// File: rtl/cmp_edge_irq_pkg.sv
package cmp_edge_irq_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_SYNC_N = 2;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_evt_t;
endpackage

// File: rtl/cmp_edge_irq_sync.sv
module cmp_edge_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[LAST];
endmodule

// File: rtl/cmp_edge_irq_edge.sv
module cmp_edge_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/cmp_edge_irq_flag.sv
module cmp_edge_irq_flag
  import cmp_edge_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_evt_t evt,
  output logic      flag
);
  logic flag_q;

  // Set wins over clear when both land on one edge.
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (evt.set) flag_q <= 1'b1;
    else if (evt.clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
  import cmp_edge_irq_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int FLAG_BIT = 0,
  parameter int SYNC_N   = DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_async,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  output logic              flag_o,
  output logic              irq_o
);
  logic      cmp_sync;
  logic      cmp_rise;
  flag_evt_t evt;

  cmp_edge_irq_sync #(.STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cmp_async),
    .dout (cmp_sync)
  );

  cmp_edge_irq_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .level(cmp_sync),
    .rise (cmp_rise)
  );

  // Only a zero in the flag's bit clears; a one is ignored.
  always_comb begin
    evt.set = cmp_rise;
    evt.clr = wr_en & ~wr_data[FLAG_BIT];
  end

  cmp_edge_irq_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (evt),
    .flag (flag_o)
  );

  assign irq_o = flag_o & irq_en;
endmodule

// File: rtl/cmp_edge_irq_chk.sv
module cmp_edge_irq_chk #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_en,
  input logic              rise,
  input logic              flag_o,
  input logic              irq_o
);
  logic clr_req;
  assign clr_req = wr_en && !wr_data[FLAG_BIT];

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !flag_o);

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> flag_o);

  // R4
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !rise) |=> !flag_o);

  // R7
  set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && rise) |=> flag_o);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !rise) |=> $stable(flag_o));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(rise));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && irq_en));

  // R8
  irq_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && irq_en) |-> irq_o);
endmodule

bind cmp_edge_irq cmp_edge_irq_chk #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .irq_en (irq_en),
  .rise   (cmp_rise),
  .flag_o (flag_o),
  .irq_o  (irq_o)
);

// File: tb/cmp_edge_irq_tb_top.sv
module cmp_edge_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_async = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_en = 1'b1;
  logic       flag_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_edge_irq dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_async(cmp_async),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .irq_en   (irq_en),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  // {req[3:0], cmp, wr, data[7:0], en, exp_flag, exp_irq}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R1 idle low
    {4'd2, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},  // R2 rise sets
    {4'd3, 1'b1, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b0},  // R3/R4 clear, stays high
    {4'd6, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0},  // R6 write one, still clear
    {4'd5, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},  // R5 fall
    {4'd5, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},  // R5 rise again
    {4'd6, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1},  // R6 write one keeps set
    {4'd8, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},  // R8 disable masks irq
    {4'd8, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1},  // R8 enable again
    {4'd4, 1'b0, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b0},  // R4 clear, other bits set
    {4'd8, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R8 idle disabled
    {4'd2, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}   // R2 set while disabled
  };

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    ticks(3);
    // R1: outputs low while held in reset
    check("R1 flag in reset", flag_o, 1'b0);
    check("R1 irq in reset", irq_o, 1'b0);
    rst_n = 1'b1;
    ticks(2);
    check("R1 flag after reset", flag_o, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [16:0] e;
      e = VEC[v];
      cmp_async = e[12];
      wr_en     = e[11];
      wr_data   = e[10:3];
      irq_en    = e[2];
      ticks(1);
      wr_en = 1'b0;
      ticks(4);
      check($sformatf("R%0d vec%0d flag", e[16:13], v), flag_o, e[1]);
      check($sformatf("R%0d vec%0d irq", e[16:13], v), irq_o, e[0]);
    end

    // R2 latency: low, then rise; not yet set after 2 edges, set after 3
    cmp_async = 1'b0; wr_en = 1'b1; wr_data = 8'h00; ticks(1); wr_en = 1'b0;
    ticks(4);
    cmp_async = 1'b1;
    ticks(2);
    check("R2 not set after two edges", flag_o, 1'b0);
    ticks(1);
    check("R2 set after third edge", flag_o, 1'b1);

    // R7: rise detected on the same edge as a clearing write
    cmp_async = 1'b0; wr_en = 1'b1; wr_data = 8'h00; ticks(1); wr_en = 1'b0;
    ticks(4);
    check("R7 precondition clear", flag_o, 1'b0);
    cmp_async = 1'b1;
    ticks(2);
    wr_en = 1'b1; wr_data = 8'h00;
    ticks(1);
    wr_en = 1'b0;
    check("R7 set wins over clear", flag_o, 1'b1);

    // R3: repeated clears while high never re-set
    wr_en = 1'b1; wr_data = 8'h00; ticks(1); wr_en = 1'b0;
    ticks(10);
    check("R3 stays clear while high", flag_o, 1'b0);

    // R1: mid-run reset clears a set flag
    cmp_async = 1'b0; ticks(4); cmp_async = 1'b1; ticks(4);
    check("R5 set before reset", flag_o, 1'b1);
    cmp_async = 1'b0;
    rst_n = 1'b0; ticks(1);
    check("R1 reset clears flag", flag_o, 1'b0);
    rst_n = 1'b1; ticks(4);
    check("R1 stays clear after reset", flag_o, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule